// File: doc/BRIEF.md
# Dual-Personality Microprocessor Register Port

This block is the host-facing register port of a larger device. An 8-bit microprocessor reaches a bank of 8-bit control registers through it. Two strap inputs reinterpret one set of pins, which gives four bus personalities. The first strap chooses between separate address and data buses and a single shared address/data bus. The second strap chooses between Intel-style strobes (separate read and write strobes plus an address-latch enable) and Motorola-style strobes (one data strobe plus a read/write direction line plus an address strobe).

All pins are sampled into the block's clock domain. Strobe edges are detected there. The block produces a one-cycle register write enable, a read enable, the register address and the write data for the register bank. It also drives the data bus, with its own output enable. A small register file sits inside the block. It holds fifteen writable registers and one fixed identification register. Every other address reads as zero and absorbs writes.

Top module: `host_bus_port`

## Requirements
- R1: After reset, `dq_oe`, `reg_we` and `reg_re` are low and every writable register reads 00h.
- R2: With `strap_moto` low, a read is active while `cs_n` and `rd_ds_n` are both low. A write commits once, when `wr_rw_n` rises after being sampled low with `cs_n` low; the committed data and address are those sampled in the last cycle with `wr_rw_n` low.
- R3: With `strap_muxed` low, the register address is `{ale_as_a7, addr_lo}`: the address-latch pin is bit 7 and `addr_lo` gives bits 6..0.
- R4: With `strap_muxed` high, the address is taken from `dq_in` in the first sample where `ale_as_a7` is high after being low. It is held for all following read and write cycles until the next such rising edge.
- R5: With `strap_moto` high, a read is active while `cs_n` is low, `rd_ds_n` is low and `wr_rw_n` is high. A write commits when `rd_ds_n` rises after being sampled low with `wr_rw_n` low and `cs_n` low.
- R6: While `cs_n` is high, no strobe activity drives the bus or changes any register.
- R7: `dq_oe` is high only during an active read with `cs_n` low. It and `dq_out` follow the pins two rising clock edges later; while `dq_oe` is low, `dq_out` is 00h.
- R8: Address 0Fh reads the fixed identification value 35h, whose bit 7 is 0. Writes to 0Fh leave it unchanged.
- R9: Addresses 10h to FFh are unimplemented (this includes the A0h to FFh bank). They read as 00h, and writes to them change no register.
- R10: Each write cycle raises `reg_we` for exactly one clock cycle.
- R11: When `reg_we` is high, `reg_addr` and `reg_wdata` show the committed address and data. `reg_bank` shows register n in bits 8n+7 to 8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_muxed | input | 1 | 0: separate address bus, 1: shared address/data bus |
| strap_moto | input | 1 | 0: Intel-style strobes, 1: Motorola-style strobes |
| cs_n | input | 1 | Chip select, active low |
| rd_ds_n | input | 1 | Read strobe (Intel) or data strobe (Motorola), active low |
| wr_rw_n | input | 1 | Write strobe (Intel) or read/write direction, high = read (Motorola) |
| ale_as_a7 | input | 1 | Address latch/strobe when multiplexed, address bit 7 otherwise |
| addr_lo | input | 7 | Address bits 6..0 in non-multiplexed mode |
| dq_in | input | 8 | Data bus input (and address phase when multiplexed) |
| dq_out | output | 8 | Data bus read value |
| dq_oe | output | 1 | Data bus output enable |
| reg_we | output | 1 | One-cycle register write enable |
| reg_re | output | 1 | Register read enable |
| reg_addr | output | 8 | Address of the current access |
| reg_wdata | output | 8 | Write data of the committed write |
| reg_bank | output | 128 | Contents of all registers, register n at bits 8n+7..8n |

## Verification
The bench goes after the points where personalities collide. A design that took bit 7 from the wrong place would write register 02h on an access to 82h. A design that latched on the level of the address strobe, not its edge, would let data-phase bytes overwrite the address. A Motorola read would be mistaken for a write if the direction line were ignored. It also drives full cycles with chip select high and writes to 0Fh and to the top bank, and then reads back to confirm that nothing moved. A cycle-accurate model compares the bus enable, read data and write pulse on every clock, so a write counted twice or a two-edge latency error shows at once.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    localparam int HB_DW = 8;
    localparam int HB_AW = 8;
    localparam int HB_LW = HB_AW - 1;

    // One sample of the host pins.
    typedef struct packed {
        logic             cs_n;
        logic             strb_n;   // RD* or DS*
        logic             dir;      // WR* or R/W*
        logic             ale;      // ALE/AS or A7
        logic [HB_LW-1:0] alo;
        logic [HB_DW-1:0] dat;
    } bus_smp_t;

    localparam bus_smp_t BUS_IDLE = '{cs_n: 1'b1, strb_n: 1'b1, dir: 1'b1,
                                      ale: 1'b0, alo: '0, dat: '0};
endpackage

// File: rtl/hbp_sampler.sv
module hbp_sampler
    import hbp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_smp_t pins,
    output bus_smp_t cur,
    output bus_smp_t prv
);
    typedef struct packed {
        bus_smp_t cur;
        bus_smp_t prv;
    } smp_state_t;

    smp_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.prv = st_q.cur;
        st_d.cur = pins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cur: BUS_IDLE, prv: BUS_IDLE};
        else        st_q <= st_d;
    end

    assign cur = st_q.cur;
    assign prv = st_q.prv;
endmodule

// File: rtl/hbp_decode.sv
module hbp_decode
    import hbp_pkg::*;
(
    input  logic     moto,
    input  bus_smp_t cur,
    input  bus_smp_t prv,
    output logic     rd_act,
    output logic     wr_commit,
    output logic     ale_rise
);
    logic intel_rd, intel_wr, moto_rd, moto_wr;

    always_comb begin
        intel_rd  = !cur.strb_n;
        intel_wr  = !prv.dir && cur.dir;
        moto_rd   = !cur.strb_n && cur.dir;
        moto_wr   = !prv.strb_n && cur.strb_n && !prv.dir;
        rd_act    = !cur.cs_n && (moto ? moto_rd : intel_rd);
        wr_commit = !prv.cs_n && (moto ? moto_wr : intel_wr);
        ale_rise  = !prv.ale && cur.ale;
    end
endmodule

// File: rtl/hbp_addr_latch.sv
module hbp_addr_latch
    import hbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             muxed,
    input  logic             ale_rise,
    input  bus_smp_t         cur,
    input  bus_smp_t         prv,
    output logic [HB_AW-1:0] rd_addr,
    output logic [HB_AW-1:0] wr_addr
);
    logic [HB_AW-1:0] latch_d, latch_q;

    always_comb begin
        latch_d = latch_q;
        if (muxed && ale_rise) latch_d = cur.dat;
        rd_addr = muxed ? latch_q : {cur.ale, cur.alo};
        wr_addr = muxed ? latch_q : {prv.ale, prv.alo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    // Address is frozen while no strobe edge arrives in shared-bus mode.
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (muxed && !cur.ale) |=> $stable(rd_addr) || !muxed)
        else $error("latch moved without strobe edge");
endmodule

// File: rtl/hbp_regfile.sv
module hbp_regfile
    import hbp_pkg::*;
#(
    parameter int               REG_COUNT = 16,
    parameter int               ID_ADDR   = 15,
    parameter logic [HB_DW-1:0] ID_VALUE  = 8'h35
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [HB_AW-1:0]           wr_addr,
    input  logic [HB_DW-1:0]           wr_data,
    input  logic [HB_AW-1:0]           rd_addr,
    output logic [HB_DW-1:0]           rd_data,
    output logic [REG_COUNT*HB_DW-1:0] bank
);
    localparam int               IDX_W  = $clog2(REG_COUNT);
    localparam logic [HB_AW-1:0] LIMIT  = HB_AW'(REG_COUNT);
    localparam logic [HB_AW-1:0] ID_A   = HB_AW'(ID_ADDR);

    logic [HB_DW-1:0] regs_d [REG_COUNT];
    logic [HB_DW-1:0] regs_q [REG_COUNT];
    logic [HB_DW-1:0] view   [REG_COUNT];

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (wr_addr < LIMIT) && (wr_addr != ID_A))
            regs_d[wr_addr[IDX_W-1:0]] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_view
        if (g == ID_ADDR) begin : g_id
            assign view[g] = ID_VALUE;
        end else begin : g_rw
            assign view[g] = regs_q[g];
        end
        assign bank[g*HB_DW +: HB_DW] = view[g];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < LIMIT) rd_data = view[rd_addr[IDX_W-1:0]];
    end

    assert_id_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ID_A) |-> (rd_data[HB_DW-1] == 1'b0))
        else $error("identification MSB set");

    assert_unimpl_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= LIMIT)) |=> $stable(bank))
        else $error("write to unimplemented address changed the bank");

    assert_id_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ID_A)) |=> $stable(bank))
        else $error("write to identification register changed the bank");
endmodule

// File: rtl/host_bus_port.sv
module host_bus_port
    import hbp_pkg::*;
#(
    parameter int               REG_COUNT = 16,
    parameter int               ID_ADDR   = 15,
    parameter logic [HB_DW-1:0] ID_VALUE  = 8'h35
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strap_muxed,
    input  logic                       strap_moto,
    input  logic                       cs_n,
    input  logic                       rd_ds_n,
    input  logic                       wr_rw_n,
    input  logic                       ale_as_a7,
    input  logic [HB_LW-1:0]           addr_lo,
    input  logic [HB_DW-1:0]           dq_in,
    output logic [HB_DW-1:0]           dq_out,
    output logic                       dq_oe,
    output logic                       reg_we,
    output logic                       reg_re,
    output logic [HB_AW-1:0]           reg_addr,
    output logic [HB_DW-1:0]           reg_wdata,
    output logic [REG_COUNT*HB_DW-1:0] reg_bank
);
    typedef struct packed {
        logic             oe;
        logic [HB_DW-1:0] dout;
        logic             we;
        logic             re;
        logic [HB_AW-1:0] addr;
        logic [HB_DW-1:0] wdata;
    } out_t;

    bus_smp_t         pins, cur, prv;
    logic             rd_act, wr_commit, ale_rise;
    logic [HB_AW-1:0] rd_addr, wr_addr;
    logic [HB_DW-1:0] rd_data;
    out_t             out_d, out_q;

    assign pins = '{cs_n: cs_n, strb_n: rd_ds_n, dir: wr_rw_n,
                    ale: ale_as_a7, alo: addr_lo, dat: dq_in};

    hbp_sampler u_smp (
        .clk  (clk),
        .rst_n(rst_n),
        .pins (pins),
        .cur  (cur),
        .prv  (prv)
    );

    hbp_decode u_dec (
        .moto     (strap_moto),
        .cur      (cur),
        .prv      (prv),
        .rd_act   (rd_act),
        .wr_commit(wr_commit),
        .ale_rise (ale_rise)
    );

    hbp_addr_latch u_adr (
        .clk     (clk),
        .rst_n   (rst_n),
        .muxed   (strap_muxed),
        .ale_rise(ale_rise),
        .cur     (cur),
        .prv     (prv),
        .rd_addr (rd_addr),
        .wr_addr (wr_addr)
    );

    hbp_regfile #(
        .REG_COUNT(REG_COUNT),
        .ID_ADDR  (ID_ADDR),
        .ID_VALUE (ID_VALUE)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_commit),
        .wr_addr(wr_addr),
        .wr_data(prv.dat),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .bank   (reg_bank)
    );

    always_comb begin
        out_d       = '0;
        out_d.oe    = rd_act;
        out_d.re    = rd_act;
        out_d.dout  = rd_act ? rd_data : '0;
        out_d.we    = wr_commit;
        out_d.addr  = wr_commit ? wr_addr : rd_addr;
        out_d.wdata = wr_commit ? prv.dat : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dq_oe     = out_q.oe;
    assign dq_out    = out_q.dout;
    assign reg_we    = out_q.we;
    assign reg_re    = out_q.re;
    assign reg_addr  = out_q.addr;
    assign reg_wdata = out_q.wdata;

    assert_oe_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> ($past(cs_n, 2) == 1'b0))
        else $error("bus driven without chip select");

    assert_we_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(cs_n, 3) == 1'b0))
        else $error("write committed without chip select");

    assert_we_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we)
        else $error("write enable longer than one cycle");
endmodule

// File: tb/tb_host_bus_port.sv
module tb_host_bus_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_muxed = 1'b0, strap_moto = 1'b0;
    logic       cs_n = 1'b1, rd_ds_n = 1'b1, wr_rw_n = 1'b1, ale_as_a7 = 1'b0;
    logic [6:0] addr_lo = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out, reg_addr, reg_wdata;
    logic       dq_oe, reg_we, reg_re;
    logic [127:0] reg_bank;

    int checks = 0, failures = 0, we_cnt = 0;
    logic [7:0] last_wa = '0, last_wd = '0;
    bit done = 0;

    always #2 clk = ~clk;

    host_bus_port dut (
        .clk(clk), .rst_n(rst_n), .strap_muxed(strap_muxed), .strap_moto(strap_moto),
        .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_rw_n(wr_rw_n), .ale_as_a7(ale_as_a7),
        .addr_lo(addr_lo), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_bank(reg_bank)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic cs_n; logic s_n; logic d; logic a; logic [6:0] lo; logic [7:0] dat;
    } pin_t;
    localparam pin_t P_IDLE = '{1'b1, 1'b1, 1'b1, 1'b0, 7'd0, 8'd0};

    pin_t h0 = P_IDLE, h1 = P_IDLE;
    logic [7:0] m_latch = '0;
    logic [7:0] m_regs [16];
    logic e_oe = 0, e_we = 0;
    logic [7:0] e_dout = '0;

    function automatic logic m_rd(pin_t p, logic mo);
        return !p.cs_n && !p.s_n && (mo ? p.d : 1'b1);
    endfunction

    function automatic logic m_wr(pin_t o, pin_t n, logic mo);
        if (o.cs_n) return 1'b0;
        if (mo) return !o.s_n && n.s_n && !o.d;
        return !o.d && n.d;
    endfunction

    function automatic logic [7:0] m_val(logic [7:0] a);
        if (a == 8'h0F) return 8'h35;
        if (a < 8'h10) return m_regs[a[3:0]];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h0 = P_IDLE; h1 = P_IDLE; m_latch = '0;
            foreach (m_regs[i]) m_regs[i] = '0;
            e_oe = 0; e_we = 0; e_dout = '0;
        end else begin
            logic [7:0] ra, wa;
            ra     = strap_muxed ? m_latch : {h0.a, h0.lo};
            e_oe   = m_rd(h0, strap_moto);
            e_dout = e_oe ? m_val(ra) : 8'h00;
            e_we   = m_wr(h1, h0, strap_moto);
            if (e_we) begin
                wa = strap_muxed ? m_latch : {h1.a, h1.lo};
                if (wa < 8'h0F) m_regs[wa[3:0]] = h1.dat;
            end
            if (strap_muxed && !h1.a && h0.a) m_latch = h0.dat;
            h1 = h0;
            h0 = '{cs_n, rd_ds_n, wr_rw_n, ale_as_a7, addr_lo, dq_in};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 model dq_oe", dq_oe, e_oe);
            chk("R7 model reg_re", reg_re, e_oe);
            if (e_oe) chk("R7 model dq_out", dq_out, e_dout);
            chk("R10 model reg_we", reg_we, e_we);
            if (reg_we) begin we_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
        end
    end

    // ---------------- bus cycle tasks ----------------
    task automatic addr_phase(input logic [7:0] a);
        if (strap_muxed) begin
            dq_in = a; ale_as_a7 = 1'b0;
            @(negedge clk) ale_as_a7 = 1'b1;
            repeat (2) @(negedge clk);
            ale_as_a7 = 1'b0;
        end else begin
            ale_as_a7 = a[7]; addr_lo = a[6:0];
        end
    endtask

    task automatic release_bus();
        cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw_n = 1'b1; ale_as_a7 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic cs_val);
        @(negedge clk);
        addr_phase(a);
        dq_in = d; cs_n = cs_val;
        if (strap_moto) wr_rw_n = 1'b0;
        @(negedge clk);
        if (strap_moto) rd_ds_n = 1'b0; else wr_rw_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 no drive during write", dq_oe, 1'b0);
        if (strap_moto) rd_ds_n = 1'b1; else wr_rw_n = 1'b1;
        @(negedge clk);
        release_bus();
    endtask

    task automatic bus_read(input logic [7:0] a, input logic cs_val,
                            output logic [7:0] v, output logic oe);
        @(negedge clk);
        addr_phase(a);
        cs_n = cs_val; rd_ds_n = 1'b0;
        if (strap_moto) wr_rw_n = 1'b1;
        repeat (4) @(negedge clk);
        v = dq_out; oe = dq_oe;
        release_bus();
        chk("R7 released after read", dq_oe, 1'b0);
    endtask

    task automatic expect_read(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v; logic oe;
        bus_read(a, 1'b0, v, oe);
        chk({tag, " oe"}, oe, 1'b1);
        chk(tag, v, exp);
    endtask

    initial begin
        int n0;
        logic [7:0] v; logic oe;
        repeat (3) @(negedge clk);
        chk("R1 reset dq_oe", dq_oe, 1'b0);
        chk("R1 reset reg_we", reg_we, 1'b0);
        chk("R1 reset bank", reg_bank, 128'h35 << 120);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_read("R1 reg00 after reset", 8'h00, 8'h00);

        // Intel, separate buses
        n0 = we_cnt;
        bus_write(8'h02, 8'hA5, 1'b0);
        chk("R10 one pulse per write", we_cnt - n0, 1);
        chk("R11 reg_addr", last_wa, 8'h02);
        chk("R11 reg_wdata", last_wd, 8'hA5);
        expect_read("R2 intel readback", 8'h02, 8'hA5);
        bus_write(8'h0E, 8'h3C, 1'b0);
        expect_read("R2 last writable", 8'h0E, 8'h3C);
        chk("R11 bank slot 2", reg_bank[23:16], 8'hA5);
        bus_write(8'h82, 8'h11, 1'b0);
        expect_read("R3 bit7 from latch pin", 8'h02, 8'hA5);
        expect_read("R9 read 82h", 8'h82, 8'h00);
        expect_read("R8 id value", 8'h0F, 8'h35);
        bus_write(8'h0F, 8'hFF, 1'b0);
        expect_read("R8 id after write", 8'h0F, 8'h35);
        bus_write(8'hA0, 8'h77, 1'b0);
        bus_write(8'hFF, 8'h77, 1'b0);
        expect_read("R9 read FFh", 8'hFF, 8'h00);
        expect_read("R9 read 10h", 8'h10, 8'h00);
        chk("R9 bank untouched", reg_bank[119:0], {8'h3C, 88'h0, 8'hA5, 16'h0});
        n0 = we_cnt;
        bus_write(8'h02, 8'h00, 1'b1);
        chk("R6 no pulse cs high", we_cnt - n0, 0);
        expect_read("R6 reg kept", 8'h02, 8'hA5);
        bus_read(8'h02, 1'b1, v, oe);
        chk("R6 no drive cs high", oe, 1'b0);

        // Intel, shared bus
        strap_muxed = 1'b1;
        bus_write(8'h05, 8'h5A, 1'b0);
        expect_read("R4 muxed readback", 8'h05, 8'h5A);
        expect_read("R4 muxed other reg", 8'h0E, 8'h3C);

        // Motorola, separate buses
        strap_muxed = 1'b0; strap_moto = 1'b1;
        bus_write(8'h07, 8'hC3, 1'b0);
        chk("R11 moto reg_addr", last_wa, 8'h07);
        expect_read("R5 moto readback", 8'h07, 8'hC3);
        expect_read("R5 moto old reg", 8'h02, 8'hA5);

        // Motorola, shared bus
        strap_muxed = 1'b1;
        bus_write(8'h09, 8'h96, 1'b0);
        expect_read("R5 moto muxed", 8'h09, 8'h96);
        expect_read("R4 moto muxed id", 8'h0F, 8'h35);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule